// File: doc/BRIEF.md
# Latency-Table Pipeline Interlock

This block sits beside the decode stage of an in-order pipeline. Each cycle it decides whether the instruction in decode may issue or must wait. The instruction would wait because one of its source registers is written by an earlier multicycle operation whose result is not yet ready. The number of cycles that must separate a producer from a consumer is not one fixed load-use delay. It is looked up from a small table indexed by the producer's class and the consumer's class.

Every architectural register has a scoreboard slot, and each slot is a two-state machine. In `SLOT_IDLE` no multicycle result is pending. In `SLOT_BUSY` the slot holds the producer's class and a countdown that starts at the largest gap in the table. The slot makes four transitions. `arm` moves IDLE to BUSY when an FP ALU or load-double instruction issues with this destination. `rearm` moves BUSY to BUSY when a new such producer issues and restarts the count. `clear` moves BUSY or IDLE to IDLE when an integer instruction writes the register. `expire` moves BUSY to IDLE when the countdown leaves 1.

A source is still blocked while the elapsed intervening cycles (the maximum minus the countdown) are fewer than the table gap for the pair. The decode stage holds a stalled instruction in place. Nothing about that instruction is recorded until it issues.

Top module: `hazard_gap_guard`

## Requirements
- R1: Class codes on `dec_class` are 0 integer, 1 FP ALU, 2 load-double and 3 store-double. Classes 0, 1 and 2 write `dec_dst` when they issue. Class 3 writes no register.
- R2: An FP ALU producer followed by an FP ALU consumer needs 3 intervening cycles. The consumer stalls in the 1st, 2nd and 3rd cycle after the producer issues, and it issues in the 4th.
- R3: An FP ALU producer followed by a store-double consumer of its result needs 2 intervening cycles, which gives exactly 2 stall cycles.
- R4: A load-double producer followed by an FP ALU consumer needs 1 intervening cycle, which gives exactly 1 stall cycle.
- R5: A load-double producer followed by a store-double consumer, and every pair not named in R2 to R4, needs 0 cycles and never stalls. This includes every pair with an integer producer.
- R6: `stall` is high only when `dec_valid` is high. `issue` equals `dec_valid` and not hazard. The two are never high together.
- R7: When several enabled sources are pending, the instruction stalls until the largest remaining requirement among them is met.
- R8: A source whose bit in `dec_src_en` is 0 never causes a stall, whatever register it names.
- R9: An instruction that stalls and is then withdrawn leaves no pending producer behind for its destination.
- R10: A later write to a register replaces the earlier record. An integer write removes a pending FP result, and a new FP producer restarts the full gap.
- R11: After reset every register is free, so no instruction stalls until a producer has issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dec_valid | input | 1 | An instruction is present in decode |
| dec_class | input | 2 | Class of the decoded instruction (R1 codes) |
| dec_dst | input | AW (5) | Destination register |
| dec_src | input | NSRC*AW (10) | Source register numbers; source k at bits [k*AW +: AW] |
| dec_src_en | input | NSRC (2) | Source k is actually read when bit k is 1 |
| stall | output | 1 | Hold the decode instruction this cycle |
| issue | output | 1 | The decode instruction issues this cycle |

## Verification
A slot with a wrong class or a wrong countdown shows up as a wrong `stall` or `issue` value. This happens in the first cycle after the producer issues, when a dependent instruction reaches decode. An off-by-one countdown changes the number of stall cycles for a pair by one. The pair-by-pair stall counts catch this directly. A record wrongly kept for a withdrawn or overwritten instruction appears as a spurious stall on the next consumer of that register. The random phase holds stalled instructions in decode and also withdraws them. It compares every cycle against a timestamp model of issue times.

// File: rtl/hgg_pkg.sv
package hgg_pkg;

    typedef enum logic [1:0] {
        OP_INT = 2'd0,
        OP_FPU = 2'd1,
        OP_LDD = 2'd2,
        OP_STD = 2'd3
    } op_cls_t;

    typedef enum logic {
        SLOT_IDLE = 1'b0,
        SLOT_BUSY = 1'b1
    } slot_st_t;

    localparam int GAP_MAX = 3;
    localparam int GAP_W   = $clog2(GAP_MAX + 1);

    // required intervening cycles between producer p and consumer c
    function automatic logic [GAP_W-1:0] req_gap(op_cls_t p, op_cls_t c);
        logic [GAP_W-1:0] g;
        g = '0;
        unique case (p)
            OP_FPU: begin
                if (c == OP_FPU)      g = GAP_W'(3);
                else if (c == OP_STD) g = GAP_W'(2);
            end
            OP_LDD: begin
                if (c == OP_FPU)      g = GAP_W'(1);
            end
            default: g = '0;
        endcase
        return g;
    endfunction

    function automatic logic is_multicycle(op_cls_t c);
        return (c == OP_FPU) || (c == OP_LDD);
    endfunction

    function automatic logic writes_reg(op_cls_t c);
        return c != OP_STD;
    endfunction

endpackage

// File: rtl/hgg_slot.sv
module hgg_slot
    import hgg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  op_cls_t          wr_cls,
    output op_cls_t          pend_cls,
    output logic [GAP_W-1:0] pend_cnt
);

    slot_st_t         st, st_n;
    op_cls_t          cls_q, cls_n;
    logic [GAP_W-1:0] cnt_q, cnt_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st    <= SLOT_IDLE;
            cls_q <= OP_INT;
            cnt_q <= '0;
        end else begin
            st    <= st_n;
            cls_q <= cls_n;
            cnt_q <= cnt_n;
        end
    end

    always_comb begin
        st_n  = st;
        cls_n = cls_q;
        cnt_n = cnt_q;
        if (wr) begin
            cls_n = wr_cls;
            if (is_multicycle(wr_cls)) begin
                st_n  = SLOT_BUSY;              // arm / rearm
                cnt_n = GAP_W'(GAP_MAX);
            end else begin
                st_n  = SLOT_IDLE;              // clear
                cnt_n = '0;
            end
        end else begin
            unique case (st)
                SLOT_IDLE: ;
                SLOT_BUSY: begin
                    cnt_n = cnt_q - 1'b1;
                    if (cnt_q == GAP_W'(1)) st_n = SLOT_IDLE;  // expire
                end
                default: st_n = SLOT_IDLE;
            endcase
        end
    end

    assign pend_cls = cls_q;
    assign pend_cnt = cnt_q;

    p_arm_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && is_multicycle(wr_cls)) |=> (cnt_q == GAP_W'(GAP_MAX)) && (st == SLOT_BUSY));

    p_countdown_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SLOT_BUSY && !wr) |=> (cnt_q == GAP_W'($past(cnt_q) - 1'b1)));

    p_idle_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SLOT_IDLE) |-> (cnt_q == '0));

    p_int_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && wr_cls == OP_INT) |=> (st == SLOT_IDLE));

endmodule

// File: rtl/hgg_src_check.sv
module hgg_src_check
    import hgg_pkg::*;
(
    input  logic             en,
    input  op_cls_t          p_cls,
    input  logic [GAP_W-1:0] p_cnt,
    input  op_cls_t          c_cls,
    output logic             need
);

    logic [GAP_W:0] sum;

    // blocked while elapsed (GAP_MAX - cnt) is below the pair's gap
    always_comb begin
        sum  = {1'b0, p_cnt} + {1'b0, req_gap(p_cls, c_cls)};
        need = en && (int'(sum) > GAP_MAX);
    end

endmodule

// File: rtl/hazard_gap_guard.sv
module hazard_gap_guard
    import hgg_pkg::*;
#(
    parameter  int NREGS = 32,
    parameter  int NSRC  = 2,
    localparam int AW    = $clog2(NREGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dec_valid,
    input  logic [1:0]        dec_class,
    input  logic [AW-1:0]     dec_dst,
    input  logic [NSRC*AW-1:0] dec_src,
    input  logic [NSRC-1:0]   dec_src_en,
    output logic              stall,
    output logic              issue
);

    op_cls_t          cur_cls;
    op_cls_t          slot_cls [NREGS];
    logic [GAP_W-1:0] slot_cnt [NREGS];
    logic [NSRC-1:0]  src_need;
    logic             hazard;

    assign cur_cls = op_cls_t'(dec_class);

    for (genvar r = 0; r < NREGS; r++) begin : g_slot
        logic wr_here;
        assign wr_here = issue && writes_reg(cur_cls) && (dec_dst == AW'(r));
        hgg_slot u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr       (wr_here),
            .wr_cls   (cur_cls),
            .pend_cls (slot_cls[r]),
            .pend_cnt (slot_cnt[r])
        );
    end

    for (genvar k = 0; k < NSRC; k++) begin : g_src
        logic [AW-1:0] idx;
        assign idx = dec_src[k*AW +: AW];
        hgg_src_check u_chk (
            .en    (dec_src_en[k]),
            .p_cls (slot_cls[idx]),
            .p_cnt (slot_cnt[idx]),
            .c_cls (cur_cls),
            .need  (src_need[k])
        );
    end

    assign hazard = |src_need;
    assign stall  = dec_valid && hazard;
    assign issue  = dec_valid && !hazard;

    p_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(stall && issue));

    p_stall_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> dec_valid);

    p_fresh_free_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !stall);

    p_masked_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_src_en == '0) |-> !stall);

endmodule

// File: tb/test_hazard_gap_guard.sv
`timescale 1ns/1ps
module test_hazard_gap_guard;

    localparam int AW = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dec_valid = 1'b0;
    logic [1:0] dec_class = 2'd0;
    logic [4:0] dec_dst = '0;
    logic [9:0] dec_src = '0;
    logic [1:0] dec_src_en = '0;
    logic       stall, issue;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int m_time [32];
    int m_cls  [32];
    bit last_stall = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    hazard_gap_guard i_hazard_gap_guard (
        .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_class(dec_class),
        .dec_dst(dec_dst), .dec_src(dec_src), .dec_src_en(dec_src_en),
        .stall(stall), .issue(issue)
    );

    // R2..R5 gap table, from the requirements
    function automatic int gap_of(int p, int c);
        if (p == 1 && c == 1) return 3;
        if (p == 1 && c == 3) return 2;
        if (p == 2 && c == 1) return 1;
        return 0;
    endfunction

    function automatic bit exp_hazard(int c, int sa, bit ea, int sb, bit eb);
        bit h = 0;
        if (ea && (cyc - m_time[sa] - 1) < gap_of(m_cls[sa], c)) h = 1;
        if (eb && (cyc - m_time[sb] - 1) < gap_of(m_cls[sb], c)) h = 1;
        return h;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s cyc=%0d actual=%0d expected=%0d", req, cyc, act, exp);
        end
    endtask

    task automatic step(bit v, int c, int d, int sa, bit ea, int sb, bit eb, string req);
        bit h, es, ei;
        @(negedge clk);
        dec_valid  = v;
        dec_class  = 2'(c);
        dec_dst    = 5'(d);
        dec_src    = {5'(sb), 5'(sa)};
        dec_src_en = {eb, ea};
        #1;
        h  = exp_hazard(c, sa, ea, sb, eb);
        es = v && h;
        ei = v && !h;
        chk({stall, issue} == {es, ei}, req, {stall, issue}, {es, ei});
        last_stall = stall;
        @(posedge clk);
        if (ei && c != 3) begin   // R1: store-double writes nothing
            m_time[d] = cyc;
            m_cls[d]  = c;
        end
        cyc++;
    endtask

    // producer then dependent consumer; count stall cycles
    task automatic run_pair(int p, int c, int rp, int rc, int exp_n, string req);
        int n = 0;
        step(1, p, rp, 0, 0, 0, 0, req);
        for (int k = 0; k < 8; k++) begin
            step(1, c, rc, rp, 1, 0, 0, req);
            if (!last_stall) break;
            n++;
        end
        chk(n == exp_n, req, n, exp_n);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int n;
        for (int r = 0; r < 32; r++) begin m_time[r] = -100; m_cls[r] = 0; end
        void'($urandom(32'h5eed));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R11: every register free after reset
        step(1, 1, 1, 7, 1, 20, 1, "R11");
        chk(issue === 1'b1, "R11", issue, 1);
        // R6: no valid, no stall and no issue
        step(0, 1, 2, 1, 1, 1, 1, "R6");

        run_pair(1, 1, 3, 4, 3, "R2");
        run_pair(1, 3, 5, 0, 2, "R3");
        run_pair(2, 1, 6, 8, 1, "R4");
        run_pair(2, 3, 9, 0, 0, "R5");
        run_pair(0, 1, 10, 11, 0, "R5");
        run_pair(1, 0, 12, 13, 0, "R5");

        // R7: FP into r14, load into r15, consumer reads both
        step(1, 1, 14, 0, 0, 0, 0, "R7");
        step(1, 2, 15, 0, 0, 0, 0, "R7");
        n = 0;
        for (int k = 0; k < 8; k++) begin
            step(1, 1, 16, 14, 1, 15, 1, "R7");
            if (!last_stall) break;
            n++;
        end
        chk(n == 2, "R7", n, 2);

        // R8: disabled source names a pending register
        step(1, 1, 17, 0, 0, 0, 0, "R8");
        step(1, 1, 18, 17, 0, 17, 0, "R8");
        chk(issue === 1'b1, "R8", issue, 1);

        // R9: stalled instruction withdrawn leaves no record
        step(1, 1, 19, 0, 0, 0, 0, "R9");
        step(1, 1, 21, 19, 1, 0, 0, "R9");
        chk(stall === 1'b1, "R9", stall, 1);
        step(0, 0, 0, 0, 0, 0, 0, "R9");
        step(1, 1, 22, 21, 1, 0, 0, "R9");
        chk(issue === 1'b1, "R9", issue, 1);

        // R10: integer write clears pending FP result
        step(1, 1, 23, 0, 0, 0, 0, "R10");
        step(1, 0, 23, 0, 0, 0, 0, "R10");
        step(1, 1, 24, 23, 1, 0, 0, "R10");
        chk(issue === 1'b1, "R10", issue, 1);
        // R10: FP rewrite restarts the full gap
        step(1, 1, 25, 0, 0, 0, 0, "R10");
        step(1, 0, 0, 0, 0, 0, 0, "R10");
        step(1, 1, 25, 0, 0, 0, 0, "R10");
        step(1, 1, 26, 25, 1, 0, 0, "R10");
        chk(stall === 1'b1, "R10", stall, 1);

        // random phase, registers 0..7 for dense hazards (R1..R10)
        begin
            bit v = 0, ea = 0, eb = 0;
            int c = 0, d = 0, sa = 0, sb = 0;
            for (int i = 0; i < 3000; i++) begin
                if (!(last_stall && ($urandom % 4) != 0)) begin
                    v  = ($urandom % 8) != 0;
                    c  = $urandom % 4;
                    d  = $urandom % 8;
                    sa = $urandom % 8;
                    sb = $urandom % 8;
                    ea = $urandom % 2;
                    eb = $urandom % 2;
                end
                step(v, c, d, sa, ea, sb, eb, "R1");
            end
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule